// File: doc/BRIEF.md
# Stereo Auto-Mute Detector

This block sits on a stereo sample path and watches the left and right words as they go by. When both channels have been idle for a long stretch, meaning that every word is either all zeros or all ones, it mutes both outputs without being told to. The moment either channel carries a word that is not idle, the mute lifts and that word goes through.

Each channel also has a manual mute input. It acts combinationally on that channel's output and does not touch the automatic detector. The detector can be switched off with an active-low enable. Samples arrive with a valid strobe and leave one cycle later with a matching strobe. A muted channel outputs a zero word.

Top module: `stereo_automute`

## Requirements
- R1: A sample is idle when the left word is all zeros or all ones and the right word is all zeros or all ones. The two channels need not hold the same pattern, and the pattern may change from one sample to the next.
- R2: While `amute_en_n` is low, the clock edge that accepts the RUN_LEN-th consecutive idle valid sample (default 8192) sets `auto_muted`. After RUN_LEN-1 such samples it is still low.
- R3: A valid sample that is not idle clears the run count and `auto_muted` at the edge that accepts it, so that sample leaves unmuted. A fresh run of RUN_LEN is then needed.
- R4: Cycles with `smp_valid` low neither advance nor break a run.
- R5: While `amute_en_n` is high, `auto_muted` is low and the run count is held at zero. Raising it clears an active auto-mute at the next edge.
- R6: `mute_left` / `mute_right` act in the same cycle on their own channel only: the flag goes high and the output word goes to zero. They do not affect the run count or `auto_muted`.
- R7: `mute_left_o` is the OR of `mute_left` and `auto_muted`, and likewise for the right channel. A channel whose flag is high outputs zero.
- R8: One cycle after a valid sample, `out_valid` is high and the unmuted output words equal the input words of that sample.
- R9: After reset, `auto_muted`, `out_valid` and both output words are zero.
- R10: The run count saturates at RUN_LEN. `auto_muted` stays set for as long as idle samples continue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe for both channels |
| left_in | input | DATA_W | Left input word |
| right_in | input | DATA_W | Right input word |
| amute_en_n | input | 1 | Active-low enable of auto-mute |
| mute_left | input | 1 | Manual left mute |
| mute_right | input | 1 | Manual right mute |
| out_valid | output | 1 | Output sample strobe |
| left_out | output | DATA_W | Left output word (zero when muted) |
| right_out | output | DATA_W | Right output word (zero when muted) |
| mute_left_o | output | 1 | Left mute flag |
| mute_right_o | output | 1 | Right mute flag |
| auto_muted | output | 1 | Shared auto-mute flag |

## Verification
The bench probes the run boundary at RUN_LEN-1 and RUN_LEN samples. A design that is off by one there would mute one sample early or one sample late. It mixes all-zero and all-one words across the channels, which a detector that compares against the previous sample would miss. It also breaks a run one sample short of the limit and then inserts gaps without valid samples into a run, to catch a counter that fails to restart or that counts idle cycles. Manual mutes are toggled in the middle of a run and the enable is raised while muted, to catch a design that couples the manual and automatic paths or that keeps a stale auto-mute.

// File: rtl/stereo_automute.sv
module stereo_automute #(
  parameter int DATA_W  = 24,
  parameter int RUN_LEN = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] left_in,
  input  logic [DATA_W-1:0] right_in,
  input  logic              amute_en_n,
  input  logic              mute_left,
  input  logic              mute_right,
  output logic              out_valid,
  output logic [DATA_W-1:0] left_out,
  output logic [DATA_W-1:0] right_out,
  output logic              mute_left_o,
  output logic              mute_right_o,
  output logic              auto_muted
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RUN_LEN - 1);

  logic [CNT_W-1:0]  run_cnt;
  logic              flag_q;
  logic              vld_q;
  logic [DATA_W-1:0] left_q, right_q;

  wire left_idle  = (left_in == '0) || (left_in == '1);
  wire right_idle = (right_in == '0) || (right_in == '1);
  wire both_idle  = left_idle && right_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
      flag_q  <= 1'b0;
    end else if (amute_en_n) begin
      run_cnt <= '0;
      flag_q  <= 1'b0;
    end else if (smp_valid) begin
      if (both_idle) begin
        if (run_cnt != CNT_MAX) run_cnt <= run_cnt + 1'b1;
        if (run_cnt >= CNT_LAST) flag_q <= 1'b1;
      end else begin
        run_cnt <= '0;
        flag_q  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
    end else begin
      vld_q <= smp_valid;
      if (smp_valid) begin
        left_q  <= left_in;
        right_q <= right_in;
      end
    end
  end

  assign auto_muted   = flag_q;
  assign mute_left_o  = mute_left  | flag_q;
  assign mute_right_o = mute_right | flag_q;
  assign out_valid    = vld_q;
  assign left_out     = mute_left_o  ? '0 : left_q;
  assign right_out    = mute_right_o ? '0 : right_q;

  p_engage_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!amute_en_n && smp_valid && both_idle && run_cnt == CNT_LAST) |=> auto_muted);

  p_flag_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    auto_muted |-> (run_cnt == CNT_MAX));

  p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!amute_en_n && smp_valid && !both_idle) |=> (!auto_muted && run_cnt == '0));

  p_gap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!amute_en_n && !smp_valid) |=> ($stable(run_cnt) && $stable(auto_muted)));

  p_disable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    amute_en_n |=> (!auto_muted && run_cnt == '0));

  p_out_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> out_valid);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CNT_MAX);

  p_muted_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_muted |-> (left_out == '0 && right_out == '0)));
endmodule

// File: tb/stereo_automute_tb.sv
module stereo_automute_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 24;
  localparam int RUN = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [DW-1:0] left_in = '0, right_in = '0;
  logic amute_en_n = 1'b0, mute_left = 1'b0, mute_right = 1'b0;
  logic out_valid, mute_left_o, mute_right_o, auto_muted;
  logic [DW-1:0] left_out, right_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stereo_automute #(.DATA_W(DW), .RUN_LEN(RUN)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .left_in(left_in), .right_in(right_in), .amute_en_n(amute_en_n),
    .mute_left(mute_left), .mute_right(mute_right),
    .out_valid(out_valid), .left_out(left_out), .right_out(right_out),
    .mute_left_o(mute_left_o), .mute_right_o(mute_right_o),
    .auto_muted(auto_muted));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] l, input logic [DW-1:0] r);
    @(negedge clk);
    left_in = l; right_in = r; smp_valid = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b0;
    end
  endtask

  task automatic idle_run(input int n);
    for (int i = 0; i < n; i++)
      push((i % 2) ? '1 : '0, (i % 3) ? '0 : '1);
  endtask

  task automatic fresh();
    @(negedge clk);
    smp_valid = 1'b0; amute_en_n = 1'b1; mute_left = 1'b0; mute_right = 1'b0;
    @(negedge clk);
    amute_en_n = 1'b0;
  endtask

  task automatic t_reset();
    check("R9 reset auto_muted", 32'(auto_muted), 0);
    check("R9 reset out_valid", 32'(out_valid), 0);
    check("R9 reset left_out", 32'(left_out), 0);
    check("R9 reset right_out", 32'(right_out), 0);
  endtask

  task automatic t_pass();
    push(24'h123456, 24'hABCDEF);
    idle(1);
    check("R8 out_valid", 32'(out_valid), 1);
    check("R8 left data", 32'(left_out), 32'h123456);
    check("R8 right data", 32'(right_out), 32'hABCDEF);
  endtask

  task automatic t_engage();
    fresh();
    idle_run(RUN - 1);
    idle(1);
    check("R2 not muted at RUN-1", 32'(auto_muted), 0);
    check("R1 mixed patterns counted", 32'(mute_left_o), 0);
    push('0, '1);
    idle(1);
    check("R2 muted at RUN", 32'(auto_muted), 1);
    check("R7 left flag from auto", 32'(mute_left_o), 1);
    check("R7 right zeroed", 32'(right_out), 0);
    idle_run(100);
    idle(1);
    check("R10 stays muted past RUN", 32'(auto_muted), 1);
  endtask

  task automatic t_release();
    push(24'h000010, '1);
    idle(1);
    check("R3 released", 32'(auto_muted), 0);
    check("R3 releasing sample passes", 32'(left_out), 32'h000010);
    idle_run(RUN - 2);
    push(24'h800000, '0);
    idle_run(RUN - 1);
    idle(1);
    check("R3 run restarted after break", 32'(auto_muted), 0);
    push('1, '1);
    idle(1);
    check("R3 full new run mutes", 32'(auto_muted), 1);
  endtask

  task automatic t_gaps();
    fresh();
    idle_run(4000);
    idle(50);
    idle_run(RUN - 4001);
    idle(20);
    check("R4 gaps not counted", 32'(auto_muted), 0);
    push('0, '0);
    idle(1);
    check("R4 gaps do not break run", 32'(auto_muted), 1);
  endtask

  task automatic t_enable();
    @(negedge clk);
    amute_en_n = 1'b1;
    @(negedge clk);
    check("R5 raise enable clears mute", 32'(auto_muted), 0);
    idle_run(RUN + 10);
    idle(1);
    check("R5 no mute while disabled", 32'(auto_muted), 0);
    amute_en_n = 1'b0;
    idle_run(RUN - 1);
    idle(1);
    check("R5 count held at zero while disabled", 32'(auto_muted), 0);
  endtask

  task automatic t_manual();
    fresh();
    push(24'h00F00F, 24'h0A0A0A);
    idle(1);
    mute_left = 1'b1;
    #1;
    check("R6 left flag immediate", 32'(mute_left_o), 1);
    check("R6 left zero immediate", 32'(left_out), 0);
    check("R6 right untouched", 32'(right_out), 32'h0A0A0A);
    check("R6 right flag low", 32'(mute_right_o), 0);
    mute_left = 1'b0;
    #1;
    check("R7 unmute restores left", 32'(left_out), 32'h00F00F);
    idle_run(RUN / 2);
    mute_right = 1'b1;
    idle_run(RUN / 2 - 1);
    mute_right = 1'b0;
    idle(1);
    check("R6 manual mute leaves auto low", 32'(auto_muted), 0);
    push('0, '1);
    idle(1);
    check("R6 manual mute does not break run", 32'(auto_muted), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass();
    t_engage();
    t_release();
    t_gaps();
    t_enable();
    t_manual();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule